// File: doc/BRIEF.md
# High-Speed Burst Lane Serializer

This block is the transmit-side sequencer for one serial data lane that alternates between a slow low-power signalling mode and a fast high-speed mode. While idle, the lane rests in the Stop state and drives both single-ended lines high. A burst request moves the lane through a two-step low-power entry pattern. The lane then enables its high-speed driver and sends a fixed synchronization byte. After that it serializes payload bytes, least significant bit first, one bit per bit-clock cycle.

Payload bytes arrive on a valid/ready byte stream, and a last flag marks the final byte of the burst. After the final bit, the line is driven to the opposite state for a programmable trailer period. The block then releases the high-speed driver and returns to Stop. If the stream runs dry before a byte carrying the last flag has been taken, the block raises a one-cycle error strobe and closes the burst with the same trailer.

The durations of both low-power entry steps and of the trailer are programmable cycle counts. The block runs entirely on the bit clock. Clock-lane handling and the analog drivers are outside it.

Top module: `hs_lane_burst_tx`

## Requirements
- R1: While idle after reset, the lane is in Stop: `lp_dp`=1, `lp_dn`=1, `hs_en`=0, `byte_ready`=0, `underrun`=0.
- R2: `burst_req` sampled high at a clock edge in Stop starts a burst. The lines become `lp_dp`=0, `lp_dn`=1 for `lp_step_cycles` cycles, then `lp_dp`=0, `lp_dn`=0 for `lp_step_cycles` cycles. A count of 0 acts as 1.
- R3: After the low-power entry, `hs_en` is 1 and both LP lines are 0 for the whole high-speed part. The first eight `hs_bit` values in time order are 0,0,0,1,1,1,0,1.
- R4: Payload bytes follow the sync byte back to back, each sent as 8 cycles of `hs_bit` starting with bit 0 and ending with bit 7. `byte_ready` is 1 in the last bit cycle of the sync byte and in the last bit cycle of every byte not flagged last. A byte is taken at an edge where `byte_ready` and `byte_valid` are both 1.
- R5: In the cycle after bit 7 of the byte flagged `byte_last`, `hs_bit` takes the inverse of that bit.
- R6: The trailer value is held for `trail_cycles` cycles (0 acts as 1). In the next cycle the lane is back in Stop, as in R1.
- R7: If `byte_valid` is 0 while `byte_ready` is 1, `underrun` is 1 for exactly the first trailer cycle. The trailer then follows R5 and R6, using the last bit actually sent (the sync byte's final 1 if no payload was taken).
- R8: `burst_req` has no effect outside Stop. A held request produces exactly one Stop cycle between the end of one trailer and the next entry step.
- R9: Reset (`rst_n` low) is asynchronous and forces the Stop outputs of R1 without waiting for a clock edge.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_req | input | 1 | Start a burst (sampled only in Stop) |
| lp_step_cycles | input | LP_W | Cycles per low-power entry step |
| trail_cycles | input | TRAIL_W | Trailer length in cycles |
| byte_data | input | BYTE_W | Payload byte |
| byte_valid | input | 1 | Payload byte present |
| byte_last | input | 1 | Payload byte ends the burst |
| byte_ready | output | 1 | Block takes a byte at this edge if valid |
| lp_dp | output | 1 | Low-power positive line level |
| lp_dn | output | 1 | Low-power negative line level |
| hs_en | output | 1 | High-speed driver enable |
| hs_bit | output | 1 | High-speed serial bit |
| underrun | output | 1 | One-cycle strobe: stream ran dry mid-burst |

## Verification
Every line output comes straight from registers. The first entry step therefore appears in the cycle right after the edge that samples `burst_req`. Each later segment (second step, sync, payload, trailer, Stop) starts exactly after the cycle count of the segments before it.

The bench builds the whole expected line pattern from the configured counts and the byte contents, indexed by the cycle since the request edge. It samples at the falling edge of each cycle, so every register update has settled. The underrun strobe is expected in exactly one cycle, the first trailer cycle. The byte count taken through the handshake is compared once the burst has closed. Reset is checked a fraction of a cycle after it is asserted, with no clock edge in between.

// File: rtl/hs_lane_pkg.sv
package hs_lane_pkg;

  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_LP01  = 3'd1,
    ST_LP00  = 3'd2,
    ST_SYNC  = 3'd3,
    ST_DATA  = 3'd4,
    ST_TRAIL = 3'd5
  } hs_state_e;

  // Line order 0,0,0,1,1,1,0,1 shifted out from bit 0 upward.
  localparam logic [7:0] SYNC_WORD = 8'hB8;

endpackage

// File: rtl/hs_step_timer.sv
module hs_step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] length,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] load_val;

  // A length of 0 behaves like 1: the segment lasts one cycle.
  always_comb begin
    load_val = (length == '0) ? '0 : length - CNT_W'(1);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

  AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R6

endmodule

// File: rtl/hs_byte_shifter.sv
module hs_byte_shifter
  import hs_lane_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_sync,
  input  logic              load_byte,
  input  logic              shift_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              bit_out,
  output logic              at_end
);

  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  idx_q, idx_d;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (load_sync) begin
      sh_d  = BYTE_W'(SYNC_WORD);
      idx_d = '0;
    end else if (load_byte) begin
      sh_d  = byte_in;
      idx_d = '0;
    end else if (shift_en) begin
      sh_d  = {1'b0, sh_q[BYTE_W-1:1]};
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign bit_out = sh_q[0];
  assign at_end  = (idx_q == IDX_LAST);

  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_sync && load_byte)); // R4
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_sync && !load_byte) |=> (bit_out == $past(sh_q[1]))); // R4

endmodule

// File: rtl/hs_lane_burst_tx.sv
module hs_lane_burst_tx
  import hs_lane_pkg::*;
#(
  parameter int LP_W    = 8,
  parameter int TRAIL_W = 8,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               burst_req,
  input  logic [LP_W-1:0]    lp_step_cycles,
  input  logic [TRAIL_W-1:0] trail_cycles,
  input  logic [BYTE_W-1:0]  byte_data,
  input  logic               byte_valid,
  input  logic               byte_last,
  output logic               byte_ready,
  output logic               lp_dp,
  output logic               lp_dn,
  output logic               hs_en,
  output logic               hs_bit,
  output logic               underrun
);

  localparam int CNT_W = (LP_W > TRAIL_W) ? LP_W : TRAIL_W;

  hs_state_e state_q, state_d;
  logic      last_q, last_d;
  logic      trail_bit_q, trail_bit_d;
  logic      err_q, err_d;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_len;
  logic             tmr_done;
  logic             load_sync, load_byte, shift_en;
  logic             sh_bit, sh_end;

  hs_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .length (tmr_len),
    .done   (tmr_done)
  );

  hs_byte_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_sync (load_sync),
    .load_byte (load_byte),
    .shift_en  (shift_en),
    .byte_in   (byte_data),
    .bit_out   (sh_bit),
    .at_end    (sh_end)
  );

  assign byte_ready = sh_end &&
                      ((state_q == ST_SYNC) || (state_q == ST_DATA && !last_q));

  always_comb begin
    state_d     = state_q;
    last_d      = last_q;
    trail_bit_d = trail_bit_q;
    err_d       = 1'b0;
    tmr_load    = 1'b0;
    tmr_len     = CNT_W'(lp_step_cycles);
    load_sync   = 1'b0;
    load_byte   = 1'b0;
    shift_en    = 1'b0;
    unique case (state_q)
      ST_STOP: begin
        if (burst_req) begin
          state_d  = ST_LP01;
          tmr_load = 1'b1;
        end
      end
      ST_LP01: begin
        if (tmr_done) begin
          state_d  = ST_LP00;
          tmr_load = 1'b1;
        end
      end
      ST_LP00: begin
        if (tmr_done) begin
          state_d   = ST_SYNC;
          load_sync = 1'b1;
          last_d    = 1'b0;
        end
      end
      ST_SYNC, ST_DATA: begin
        if (!sh_end) begin
          shift_en = 1'b1;
        end else if (byte_ready && byte_valid) begin
          state_d   = ST_DATA;
          load_byte = 1'b1;
          last_d    = byte_last;
        end else begin
          state_d     = ST_TRAIL;
          trail_bit_d = ~sh_bit;
          tmr_load    = 1'b1;
          tmr_len     = CNT_W'(trail_cycles);
          err_d       = byte_ready;
        end
      end
      ST_TRAIL: begin
        if (tmr_done) begin
          state_d = ST_STOP;
        end
      end
      default: state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_STOP;
      last_q      <= 1'b0;
      trail_bit_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      last_q      <= last_d;
      trail_bit_q <= trail_bit_d;
      err_q       <= err_d;
    end
  end

  always_comb begin
    lp_dp  = 1'b0;
    lp_dn  = 1'b0;
    hs_en  = 1'b0;
    hs_bit = 1'b0;
    unique case (state_q)
      ST_STOP:  begin lp_dp = 1'b1; lp_dn = 1'b1; end
      ST_LP01:  lp_dn = 1'b1;
      ST_LP00:  ;
      ST_SYNC, ST_DATA: begin hs_en = 1'b1; hs_bit = sh_bit; end
      ST_TRAIL: begin hs_en = 1'b1; hs_bit = trail_bit_q; end
      default:  begin lp_dp = 1'b1; lp_dn = 1'b1; end
    endcase
  end

  assign underrun = err_q;

  AST_STOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_dp && lp_dn) |=> ((lp_dp && lp_dn) || (!lp_dp && lp_dn))); // R2
  AST_HS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> $past(!lp_dp && !lp_dn)); // R3
  AST_HS_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (!lp_dp && !lp_dn)); // R3
  AST_TRAIL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRAIL && $past(state_q) != ST_TRAIL) |-> (hs_bit != $past(hs_bit))); // R5
  AST_TRAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRAIL && $past(state_q) == ST_TRAIL) |-> $stable(hs_bit)); // R6
  AST_TRAIL_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_en) |-> (lp_dp && lp_dn)); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun); // R7
  AST_READY_IN_HS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> hs_en); // R4

endmodule

// File: tb/hs_lane_burst_tx_tb.sv
module hs_lane_burst_tx_tb;

  typedef struct packed {
    logic [7:0] lp;
    logic [7:0] tr;
    logic [3:0] nb;
    logic       has_last;
    logic [7:0] seed;
  } vec_t;

  // lp step, trailer, byte count, last flag present, byte seed
  localparam vec_t VECS [5] = '{
    '{8'd1, 8'd1, 4'd1, 1'b1, 8'hA5},
    '{8'd3, 8'd4, 4'd3, 1'b1, 8'h3C},
    '{8'd0, 8'd2, 4'd2, 1'b1, 8'hFF},
    '{8'd2, 8'd0, 4'd2, 1'b0, 8'h00},
    '{8'd1, 8'd3, 4'd0, 1'b0, 8'h5A}
  };

  logic       clk, rst_n, burst_req;
  logic [7:0] lp_cfg, tr_cfg;
  logic [7:0] byte_data;
  logic       byte_valid, byte_last, byte_ready;
  logic       lp_dp, lp_dn, hs_en, hs_bit, underrun;

  int         n_run, n_fail, cyc;
  int         idx, feed_nb;
  logic       feed_clr, feed_has_last;
  logic [7:0] feed_seed;

  function automatic logic [7:0] byte_of(logic [7:0] seed, int i);
    return seed + 8'(i * 75);
  endfunction

  hs_lane_burst_tx u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .burst_req      (burst_req),
    .lp_step_cycles (lp_cfg),
    .trail_cycles   (tr_cfg),
    .byte_data      (byte_data),
    .byte_valid     (byte_valid),
    .byte_last      (byte_last),
    .byte_ready     (byte_ready),
    .lp_dp          (lp_dp),
    .lp_dn          (lp_dn),
    .hs_en          (hs_en),
    .hs_bit         (hs_bit),
    .underrun       (underrun)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign byte_data  = byte_of(feed_seed, idx);
  assign byte_valid = (idx < feed_nb);
  assign byte_last  = feed_has_last && (idx == feed_nb - 1);

  always @(posedge clk) begin
    if (feed_clr) idx <= 0;
    else if (byte_ready && byte_valid) idx <= idx + 1;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [4:0] obs();
    return {lp_dp, lp_dn, hs_en, hs_bit, underrun};
  endfunction

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    n_fail++;
    $display("FAIL watchdog: actual %0d expected < 150000 cycles", wd);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0; burst_req = 1'b0; lp_cfg = 8'd1; tr_cfg = 8'd1;
    feed_clr = 1'b1; feed_nb = 0; feed_has_last = 1'b0; feed_seed = 8'h00;
    #1;
    check(obs() == 5'b11000, "R9 outputs in reset", obs(), 5'b11000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(obs() == 5'b11000 && !byte_ready, "R1 idle Stop", obs(), 5'b11000);

    // Table-driven bursts
    foreach (VECS[v]) begin
      int ne, me, nb, len, hs0, dat0;
      logic [4:0] e;
      logic lastb;
      string tag;
      ne  = (VECS[v].lp == 0) ? 1 : int'(VECS[v].lp);
      me  = (VECS[v].tr == 0) ? 1 : int'(VECS[v].tr);
      nb  = int'(VECS[v].nb);
      hs0 = 2 * ne;
      dat0 = hs0 + 8;
      len = dat0 + 8 * nb + me;
      lastb = (nb == 0) ? 1'b1 : byte_of(VECS[v].seed, nb - 1)[7];
      lp_cfg = VECS[v].lp; tr_cfg = VECS[v].tr;
      feed_nb = nb; feed_has_last = VECS[v].has_last; feed_seed = VECS[v].seed;
      feed_clr = 1'b1;
      @(negedge clk);
      feed_clr = 1'b0;
      burst_req = 1'b1;
      @(negedge clk);
      burst_req = 1'b0;
      for (int c = 0; c < len + 3; c++) begin
        cyc = c;
        if (c < ne) begin
          e = 5'b01000; tag = "R2 first entry step";
        end else if (c < hs0) begin
          e = 5'b00000; tag = "R2 second entry step";
        end else if (c < dat0) begin
          e = {4'b0010, 1'b0}; e[1] = SYNC_BIT(c - hs0); tag = "R3 sync byte";
        end else if (c < len - me) begin
          e = 5'b00100; e[1] = byte_of(VECS[v].seed, (c - dat0) / 8)[(c - dat0) % 8];
          tag = "R4 payload bit";
        end else if (c < len) begin
          e = 5'b00100; e[1] = ~lastb;
          e[0] = (!VECS[v].has_last && c == len - me);
          tag = (c == len - me) ? (VECS[v].has_last ? "R5 trailer toggle" : "R7 underrun trailer")
                                : "R6 trailer hold";
        end else begin
          e = 5'b11000; tag = "R6 back to Stop";
        end
        check(obs() == e, tag, obs(), e);
        burst_req = (c == 5);   // R8: ignored mid-burst
        @(negedge clk);
      end
      check(idx == nb, "R4 bytes taken", idx, nb);
    end

    // R8: held request gives exactly one Stop cycle between bursts
    lp_cfg = 8'd1; tr_cfg = 8'd1;
    feed_nb = 1; feed_has_last = 1'b1; feed_seed = 8'h11;
    feed_clr = 1'b1;
    @(negedge clk);
    feed_clr = 1'b0;
    burst_req = 1'b1;
    @(negedge clk);
    repeat (2 + 8 + 8 + 1) @(negedge clk);
    cyc = 19;
    check(obs() == 5'b11000, "R8 single Stop cycle", obs(), 5'b11000);
    @(negedge clk);
    cyc = 20;
    check(obs() == 5'b01000, "R8 held request re-enters", obs(), 5'b01000);
    burst_req = 1'b0;
    repeat (40) @(negedge clk);
    check(obs() == 5'b11000, "R1 Stop after burst", obs(), 5'b11000);

    // R9: reset mid-burst takes effect without a clock edge
    feed_clr = 1'b1;
    @(negedge clk);
    feed_clr = 1'b0;
    burst_req = 1'b1;
    @(negedge clk);
    burst_req = 1'b0;
    repeat (4) @(negedge clk);
    check(hs_en == 1'b1, "R3 high-speed before reset", hs_en, 1);
    #1 rst_n = 1'b0;
    #1;
    check(obs() == 5'b11000, "R9 async reset mid-burst", obs(), 5'b11000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(obs() == 5'b11000, "R1 Stop after reset release", obs(), 5'b11000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic SYNC_BIT(int k);
    logic [7:0] line_order;
    line_order = 8'b1011_1000;   // bit k is the k-th bit on the line
    return line_order[k];
  endfunction

endmodule